// File: doc/BRIEF.md
# Real-Mode Segmented Address Generator

This block turns a 16-bit offset into a 20-bit physical address the way a real-mode segmented processor does. It holds four 16-bit segment registers: code, data, extra and stack. A synchronous write port loads them. For each request the caller gives an access kind, an offset, an access size and two control bits. The block picks a segment from these and adds the segment, shifted left by four bits, to the offset. Any carry out of the top bit is dropped, so every address stays inside the 1 MB space.

Alongside the physical address the block gives the normalized pointer for it. The normalized segment is the top sixteen bits of the physical address and the normalized offset is the bottom four bits. Two pointers that reach the same byte therefore compare equal. When alignment checking is enabled, the block also raises a fault flag for word or doubleword accesses that are not aligned. The address, the normalized pointer and the fault flag are combinational and respond in the same cycle as the request. Only the segment registers are clocked.

Top module: `rmseg_addr_gen`

## Requirements
- R1: `phys_addr` equals (segment × 16 + offset) using the selected segment; for example segment 1000h with offset 1F00h gives 11F00h.
- R2: A carry out of bit 19 is discarded, so segment FFFFh with offset 0010h gives 00000h.
- R3: Access kind 0 (instruction fetch) always uses the code segment, and `use_extra` has no effect on a fetch.
- R4: With `use_extra` low, access kind 1 (data) uses the data segment, kind 2 (stack) uses the stack segment, and kind 3 behaves as data.
- R5: With `use_extra` high, access kinds 1, 2 and 3 use the extra segment.
- R6: `norm_seg` equals `phys_addr[19:4]` and `norm_off` equals `phys_addr[3:0]`, so `norm_off` is always in 0..0Fh.
- R7: Segment:offset pairs that map to the same physical address give identical normalized outputs; 11F0:0000, 1100:0F00, 1080:1700 and 1000:1F00 all give 11F0:0.
- R8: When `align_chk` is high, `align_fault` is 1 for a word access (size 1) with offset bit 0 set, and for a doubleword access (size 2 or 3) with offset bits 1:0 not both zero. A byte access (size 0) never faults.
- R9: When `align_chk` is low, `align_fault` is 0 for every access.
- R10: When `seg_we` is high at a rising clock edge, the register chosen by `seg_wsel` (0 code, 1 data, 2 extra, 3 stack) takes `seg_wdata`. When `seg_we` is low, no register changes.
- R11: When `rst` is high at a rising clock edge, all four segment registers become zero.
- R12: `phys_addr`, `norm_seg`, `norm_off` and `align_fault` follow the request inputs in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| seg_we | input | 1 | Segment register write enable |
| seg_wsel | input | 2 | Register to write: 0 code, 1 data, 2 extra, 3 stack |
| seg_wdata | input | 16 | Value to write |
| acc_kind | input | 2 | 0 fetch, 1 data, 2 stack, 3 data |
| use_extra | input | 1 | Selects the extra segment for non-fetch accesses |
| offset | input | 16 | Offset within the segment |
| acc_size | input | 2 | 0 byte, 1 word, 2 or 3 doubleword |
| align_chk | input | 1 | Enables the alignment fault |
| phys_addr | output | 20 | Physical address |
| norm_seg | output | 16 | Normalized segment |
| norm_off | output | 4 | Normalized offset |
| align_fault | output | 1 | Misaligned access flag |

## Verification
The hardest case to reach is a wrap of the 1 MB space. It needs a segment register already loaded near FFFFh, and then an access of the right kind with an offset large enough to carry past bit 19. The stimulus first loads such values into each register through the write port, then sends accesses of every kind at them, with and without the extra-segment select. Alias checks load four different segment values one after another and pair each with its matching offset. Each of these cases is compared with a behavioural model of the register file that the bench updates at the clock edge.

// File: rtl/rmseg_pkg.sv
package rmseg_pkg;
    parameter int SEG_W   = 16;
    parameter int OFF_W   = 16;
    parameter int NORM_SH = 4;
    parameter int NSEG    = 4;
    localparam int PA_W   = SEG_W + NORM_SH;
    localparam int SEL_W  = $clog2(NSEG);

    typedef enum logic [1:0] {
        SEG_CODE  = 2'd0,
        SEG_DATA  = 2'd1,
        SEG_EXTRA = 2'd2,
        SEG_STACK = 2'd3
    } seg_id_e;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_DATA  = 2'd1,
        ACC_STACK = 2'd2,
        ACC_DATA2 = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        SZ_BYTE   = 2'd0,
        SZ_WORD   = 2'd1,
        SZ_DWORD  = 2'd2,
        SZ_DWORD2 = 2'd3
    } acc_size_e;

    typedef logic [SEG_W-1:0] seg_t;

    typedef struct packed {
        logic [NSEG-1:0][SEG_W-1:0] seg;
    } bank_st_t;
endpackage

// File: rtl/rmseg_seg_bank.sv
module rmseg_seg_bank
    import rmseg_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [SEL_W-1:0]           wr_sel,
    input  logic [SEG_W-1:0]           wr_data,
    output logic [NSEG-1:0][SEG_W-1:0] segs_o
);
    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d = '0;
        end else if (wr_en) begin
            st_d.seg[wr_sel] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign segs_o = st_q.seg;

    // R10: a write lands in the chosen register on the next edge
    p_load_r10: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> segs_o[$past(wr_sel)] == $past(wr_data));

    // R10: without a write the bank keeps its contents
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(segs_o));
endmodule

// File: rtl/rmseg_seg_select.sv
module rmseg_seg_select
    import rmseg_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  acc_kind_e                  kind,
    input  logic                       use_extra,
    input  logic [NSEG-1:0][SEG_W-1:0] segs,
    output seg_id_e                    sel_id,
    output logic [SEG_W-1:0]           sel_seg
);
    seg_id_e id_d;

    always_comb begin
        unique case (kind)
            ACC_FETCH: id_d = SEG_CODE;
            ACC_STACK: id_d = use_extra ? SEG_EXTRA : SEG_STACK;
            default:   id_d = use_extra ? SEG_EXTRA : SEG_DATA;
        endcase
    end

    assign sel_id  = id_d;
    assign sel_seg = segs[id_d];

    // R3: fetches read the code register whatever the override says
    p_fetch_code_r3: assert property (@(posedge clk) disable iff (rst)
        kind == ACC_FETCH |-> sel_seg == segs[SEG_CODE]);

    // R5: override on a non-fetch access reads the extra register
    p_override_extra_r5: assert property (@(posedge clk) disable iff (rst)
        (kind != ACC_FETCH && use_extra) |-> sel_seg == segs[SEG_EXTRA]);

    // R4: stack without override reads the stack register
    p_stack_default_r4: assert property (@(posedge clk) disable iff (rst)
        (kind == ACC_STACK && !use_extra) |-> sel_seg == segs[SEG_STACK]);
endmodule

// File: rtl/rmseg_addr_calc.sv
module rmseg_addr_calc
    import rmseg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SEG_W-1:0] seg,
    input  logic [OFF_W-1:0] off,
    input  acc_size_e        size,
    input  logic             chk_en,
    output logic [PA_W-1:0]  pa,
    output logic [SEG_W-1:0] nseg,
    output logic [NORM_SH-1:0] noff,
    output logic             fault
);
    localparam int HI_W = OFF_W - NORM_SH;

    logic [SEG_W-1:0] hi_sum;
    logic             mis_word, mis_dword;

    // The low NORM_SH bits of the offset pass straight through; only the
    // upper part needs an adder, and its carry out is dropped (1 MB wrap).
    always_comb begin
        hi_sum    = seg + SEG_W'(off[OFF_W-1:NORM_SH]);
        mis_word  = off[0];
        mis_dword = |off[1:0];
        unique case (size)
            SZ_BYTE: fault = 1'b0;
            SZ_WORD: fault = chk_en & mis_word;
            default: fault = chk_en & mis_dword;
        endcase
    end

    assign pa   = {hi_sum, off[NORM_SH-1:0]};
    assign nseg = pa[PA_W-1:NORM_SH];
    assign noff = pa[NORM_SH-1:0];

    // R2: the address minus the shifted segment, modulo 1 MB, is the offset
    p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (pa - {seg, {NORM_SH{1'b0}}}) == PA_W'(off));

    // R9: no fault while checking is off
    p_gate_r9: assert property (@(posedge clk) disable iff (rst)
        !chk_en |-> !fault);

    // R8: byte accesses never fault
    p_byte_r8: assert property (@(posedge clk) disable iff (rst)
        size == SZ_BYTE |-> !fault);

    // R8: a fault always comes from a misaligned low offset bit
    p_cause_r8: assert property (@(posedge clk) disable iff (rst)
        fault |-> (off[1:0] != 2'b00));

    initial begin
        if (HI_W <= 0) $error("offset narrower than normalization shift");
    end
endmodule

// File: rtl/rmseg_addr_gen.sv
module rmseg_addr_gen
    import rmseg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        seg_we,
    input  logic [1:0]  seg_wsel,
    input  logic [15:0] seg_wdata,
    input  logic [1:0]  acc_kind,
    input  logic        use_extra,
    input  logic [15:0] offset,
    input  logic [1:0]  acc_size,
    input  logic        align_chk,
    output logic [19:0] phys_addr,
    output logic [15:0] norm_seg,
    output logic [3:0]  norm_off,
    output logic        align_fault
);
    logic [NSEG-1:0][SEG_W-1:0] segs;
    seg_id_e                    sel_id;
    logic [SEG_W-1:0]           sel_seg;

    rmseg_seg_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (seg_we),
        .wr_sel  (seg_wsel),
        .wr_data (seg_wdata),
        .segs_o  (segs)
    );

    rmseg_seg_select u_sel (
        .clk       (clk),
        .rst       (rst),
        .kind      (acc_kind_e'(acc_kind)),
        .use_extra (use_extra),
        .segs      (segs),
        .sel_id    (sel_id),
        .sel_seg   (sel_seg)
    );

    rmseg_addr_calc u_calc (
        .clk    (clk),
        .rst    (rst),
        .seg    (sel_seg),
        .off    (offset),
        .size   (acc_size_e'(acc_size)),
        .chk_en (align_chk),
        .pa     (phys_addr),
        .nseg   (norm_seg),
        .noff   (norm_off),
        .fault  (align_fault)
    );

    // R11: after a reset edge the bank reads zero through every path
    p_reset_clear_r11: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (segs == '0));

    // R6/R7: the normalized pair rebuilds the physical address
    p_norm_rebuild_r6: assert property (@(posedge clk) disable iff (rst)
        ({norm_seg, 4'h0} + {16'h0, norm_off}) == phys_addr);

    // R3: a fetch never reports the extra register as its source
    p_fetch_id_r3: assert property (@(posedge clk) disable iff (rst)
        acc_kind == 2'd0 |-> sel_id == SEG_CODE);
endmodule

// File: tb/rmseg_addr_gen_tb.sv
module rmseg_addr_gen_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst;
    logic        seg_we;
    logic [1:0]  seg_wsel;
    logic [15:0] seg_wdata;
    logic [1:0]  acc_kind;
    logic        use_extra;
    logic [15:0] offset;
    logic [1:0]  acc_size;
    logic        align_chk;
    logic [19:0] phys_addr;
    logic [15:0] norm_seg;
    logic [3:0]  norm_off;
    logic        align_fault;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 0;

    // behavioural model: 0 code, 1 data, 2 extra, 3 stack
    logic [15:0] mseg [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    rmseg_addr_gen dut_i (
        .clk(clk), .rst(rst), .seg_we(seg_we), .seg_wsel(seg_wsel),
        .seg_wdata(seg_wdata), .acc_kind(acc_kind), .use_extra(use_extra),
        .offset(offset), .acc_size(acc_size), .align_chk(align_chk),
        .phys_addr(phys_addr), .norm_seg(norm_seg), .norm_off(norm_off),
        .align_fault(align_fault)
    );

    function automatic int pick_reg(input logic [1:0] kind, input logic ov);
        if (kind == 2'd0) return 0;
        if (ov) return 2;
        if (kind == 2'd2) return 3;
        return 1;
    endfunction

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    endtask

    // Drives one request after a falling edge, checks the outputs a quarter
    // period later (same cycle, R12), then lets the rising edge apply any write.
    task automatic apply(input string tag, input bit we, input bit [1:0] ws,
                         input bit [15:0] wd, input bit [1:0] kind, input bit ov,
                         input bit [15:0] off, input bit [1:0] sz, input bit chk);
        logic [19:0] e_pa;
        logic        e_flt;
        @(negedge clk);
        rst = 0; seg_we = we; seg_wsel = ws; seg_wdata = wd;
        acc_kind = kind; use_extra = ov; offset = off; acc_size = sz; align_chk = chk;
        #(CLK_PERIOD/4);
        e_pa  = 20'(({4'h0, mseg[pick_reg(kind, ov)]} << 4) + {4'h0, off});
        e_flt = chk && ((sz == 2'd1 && off[0]) || (sz[1] && off[1:0] != 2'b00));
        n_vec++;
        if (phys_addr !== e_pa || norm_seg !== e_pa[19:4] || norm_off !== e_pa[3:0]
            || align_fault !== e_flt) begin
            n_fail++;
            $display("FAIL %s: pa=%05h norm=%04h:%01h flt=%0b exp pa=%05h norm=%04h:%01h flt=%0b",
                     tag, phys_addr, norm_seg, norm_off, align_fault,
                     e_pa, e_pa[19:4], e_pa[3:0], e_flt);
        end
        @(posedge clk);
        if (we) mseg[ws] = wd;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; seg_we = 1; seg_wsel = 2'd1; seg_wdata = 16'hBEEF;
        @(posedge clk);
        @(posedge clk);
        for (int i = 0; i < 4; i++) mseg[i] = 16'h0;
    endtask

    task automatic wr(input bit [1:0] ws, input bit [15:0] wd);
        apply("R10", 1, ws, wd, 2'd1, 0, 16'h0000, 2'd0, 0);
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not end, exp completion");
            report();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) mseg[i] = 16'hxxxx;
        seg_we = 0; seg_wsel = 0; seg_wdata = 0; acc_kind = 0; use_extra = 0;
        offset = 0; acc_size = 0; align_chk = 0; rst = 1;
        repeat (3) @(posedge clk);
        for (int i = 0; i < 4; i++) mseg[i] = 16'h0;

        // R11: reset state, every register reads zero
        apply("R11", 0, 0, 0, 2'd0, 0, 16'h0000, 2'd0, 0);
        apply("R11", 0, 0, 0, 2'd2, 0, 16'h0000, 2'd0, 0);
        apply("R11", 0, 0, 0, 2'd1, 1, 16'h0000, 2'd0, 0);

        // R10: load all four registers with distinct values
        wr(2'd0, 16'h1000); wr(2'd1, 16'h2000); wr(2'd2, 16'h3000); wr(2'd3, 16'h4000);

        // R1: worked example 1000:1F00 -> 11F00 through the code register
        apply("R1", 0, 0, 0, 2'd0, 0, 16'h1F00, 2'd0, 0);
        // R3: override ignored on fetch
        apply("R3", 0, 0, 0, 2'd0, 1, 16'h0123, 2'd0, 0);
        // R4: data, stack and kind 3 defaults
        apply("R4", 0, 0, 0, 2'd1, 0, 16'h0456, 2'd0, 0);
        apply("R4", 0, 0, 0, 2'd2, 0, 16'h0789, 2'd0, 0);
        apply("R4", 0, 0, 0, 2'd3, 0, 16'hFFFF, 2'd0, 0);
        // R5: override on data, stack, kind 3
        apply("R5", 0, 0, 0, 2'd1, 1, 16'h0011, 2'd0, 0);
        apply("R5", 0, 0, 0, 2'd2, 1, 16'h0022, 2'd0, 0);
        apply("R5", 0, 0, 0, 2'd3, 1, 16'h0033, 2'd0, 0);
        // R12: output follows a same-cycle write request with the old value
        apply("R12", 1, 2'd1, 16'h5555, 2'd1, 0, 16'h0001, 2'd0, 0);
        // R10: the write above is now visible; idle cycle must not change it
        apply("R10", 0, 2'd1, 16'hAAAA, 2'd1, 0, 16'h0001, 2'd0, 0);
        apply("R10", 0, 0, 0, 2'd1, 0, 16'h0002, 2'd0, 0);

        // R2: wrap past 1 MB on each register
        wr(2'd0, 16'hFFFF); wr(2'd1, 16'hFFFF); wr(2'd2, 16'hFFF0); wr(2'd3, 16'hF800);
        apply("R2", 0, 0, 0, 2'd0, 0, 16'h0010, 2'd0, 0);
        apply("R2", 0, 0, 0, 2'd1, 0, 16'hFFFF, 2'd0, 0);
        apply("R2", 0, 0, 0, 2'd2, 1, 16'h0100, 2'd0, 0);
        apply("R2", 0, 0, 0, 2'd2, 0, 16'h8000, 2'd0, 0);
        apply("R6", 0, 0, 0, 2'd1, 0, 16'h000F, 2'd0, 0);

        // R7: four aliases of 11F00 give 11F0:0
        wr(2'd1, 16'h11F0); apply("R7", 0, 0, 0, 2'd1, 0, 16'h0000, 2'd0, 0);
        wr(2'd1, 16'h1100); apply("R7", 0, 0, 0, 2'd1, 0, 16'h0F00, 2'd0, 0);
        wr(2'd1, 16'h1080); apply("R7", 0, 0, 0, 2'd1, 0, 16'h1700, 2'd0, 0);
        wr(2'd1, 16'h1000); apply("R7", 0, 0, 0, 2'd1, 0, 16'h1F00, 2'd0, 0);

        // R8 / R9: every size against every low-offset pattern
        for (int s = 0; s < 4; s++) begin
            for (int lo = 0; lo < 4; lo++) begin
                apply("R8", 0, 0, 0, 2'd1, 0, 16'h2000 + 16'(lo), 2'(s), 1);
                apply("R9", 0, 0, 0, 2'd1, 0, 16'h2000 + 16'(lo), 2'(s), 0);
            end
        end

        // R11: mid-run reset clears loaded registers, write during reset lost
        do_reset();
        apply("R11", 0, 0, 0, 2'd1, 0, 16'h1234, 2'd0, 0);
        apply("R11", 0, 0, 0, 2'd2, 0, 16'h1234, 2'd0, 0);

        // R1: mixed random traffic with writes interleaved
        for (int n = 0; n < 400; n++) begin
            apply("R1", 1'($urandom_range(0, 3) == 0), 2'($urandom), 16'($urandom),
                  2'($urandom), 1'($urandom), 16'($urandom), 2'($urandom), 1'($urandom));
        end

        done = 1;
        report();
        $finish;
    end
endmodule